// File: doc/BRIEF.md
# Isochronous Audio Packet Deframer

This block takes the payload of one isochronous audio packet as a stream of 32-bit quadlets. The first quadlet carries a start marker and the last carries an end marker. It checks the two header quadlets of the common isochronous packet format and keeps the sample-rate code they announce. It then walks the payload as data blocks whose length in quadlets comes from the header. The first quadlet of each block carries a MIDI byte, and the remaining quadlets carry labelled 24-bit PCM samples.

PCM samples leave with the index of their channel inside the block. MIDI bytes leave with a port index, because successive blocks share one MIDI slot across eight ports. Across packets the block keeps a running expectation of the data-block counter and reports a break in it. Packets with a bad header produce nothing and give one error pulse. A packet that ends partway through a block also gives an error pulse and does not move the counter expectation. Every output is registered and appears on the clock edge that follows the quadlet that caused it.

Top module: `iso_amdtp_deframer`

## Requirements
- R1: A header is accepted only if every one of these holds: quadlet 0 bits 31:30 are 00, quadlet 0 bits 15:8 are zero, the block size in quadlet 0 bits 23:16 lies in 1..MAX_DBS, quadlet 1 bits 31:30 are 10, and quadlet 1 bits 29:24 are 010000. Otherwise `hdr_err` pulses for one cycle after quadlet 1, and the rest of the packet produces no output at all.
- R2: `rate_code` takes quadlet 1 bits 18:16 one cycle after an accepted header. It holds its value otherwise, and it resets to 0.
- R3: In slot k ≥ 1 of a block, a quadlet whose top byte is 0x40 raises `pcm_valid` on the next cycle, with `pcm_chan` = k−1 and `pcm_data` = bits 23:0.
- R4: A quadlet in a PCM slot whose top byte is not 0x40 produces no output.
- R5: In slot 0 of a block, a quadlet whose top byte is 0x81 raises `midi_valid` on the next cycle, with `midi_byte` = bits 23:16 and `midi_port` = (header block count + block index in the packet) mod 8. Any other slot-0 value, 0x80000000 included, produces no output.
- R6: `len_err` pulses one cycle after the end marker when either the body is not a whole number of blocks or the packet ends within its first quadlet. Such a packet leaves the counter expectation unchanged.
- R7: A well-formed packet with at least one block sets the expectation to (block count + blocks carried) mod 256. If an earlier such packet exists and the block count differs from the expectation, `dbc_err` pulses one cycle after the end marker.
- R8: A packet carrying only the header is valid. It raises no error, whatever its block count, and it leaves the expectation unchanged.
- R9: A start marker always begins a new header and abandons any packet in progress. Quadlets that arrive outside a packet, and cycles with `in_valid` low, produce no output.
- R10: After reset all pulses are low and no expectation exists, so the first well-formed packet never raises `dbc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Quadlet present on in_data |
| in_sop | input | 1 | Quadlet is the first of a packet |
| in_eop | input | 1 | Quadlet is the last of a packet |
| in_data | input | 32 | Payload quadlet |
| pcm_valid | output | 1 | PCM sample valid this cycle |
| pcm_chan | output | $clog2(MAX_DBS) | Channel index of the sample |
| pcm_data | output | 24 | PCM sample |
| midi_valid | output | 1 | MIDI byte valid this cycle |
| midi_port | output | 3 | MIDI port index |
| midi_byte | output | 8 | MIDI byte |
| rate_code | output | 3 | Sample-rate code from the last accepted header |
| hdr_err | output | 1 | Header rejected (pulse) |
| len_err | output | 1 | Malformed packet length (pulse) |
| dbc_err | output | 1 | Block counter discontinuity (pulse) |

## Verification
A wrong slot position in the block shows up on the very next quadlet: a sample comes out with a shifted `pcm_chan`, or a PCM word is taken for a MIDI slot. A wrong block index shows up in `midi_port` at the following block boundary. A corrupted counter expectation, or a stale one left by a rejected or truncated packet, stays hidden until the next well-formed packet with blocks ends, and then shows as a wrong or missing `dbc_err`. The sweep therefore places a correct packet straight after every error case.

// File: rtl/iso_deframer_pkg.sv
package iso_deframer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR1,
    ST_BODY,
    ST_DROP
  } dfr_state_e;

  localparam logic [5:0] FMT_AUDIO  = 6'b010000;
  localparam logic [7:0] LBL_PCM    = 8'h40;
  localparam logic [7:0] LBL_MIDI1  = 8'h81;

  // fixed bits and format code of both header quadlets
  function automatic logic hdr_fixed_ok(input logic [1:0] q0_tag,
                                        input logic [7:0] q0_pad,
                                        input logic [7:0] q1_top);
    return (q0_tag == 2'b00) && (q0_pad == 8'h00) &&
           (q1_top[7:6] == 2'b10) && (q1_top[5:0] == FMT_AUDIO);
  endfunction

  // expected block count of the following packet
  function automatic logic [7:0] dbc_advance(input logic [7:0] dbc,
                                             input logic [7:0] nblk);
    return dbc + nblk;
  endfunction

  // MIDI port owning a block: low bits of the absolute block number
  function automatic logic [2:0] midi_port_of(input logic [2:0] dbc_lo,
                                              input logic [2:0] blk_lo);
    return dbc_lo + blk_lo;
  endfunction

endpackage

// File: rtl/iso_hdr_unit.sv
module iso_hdr_unit
  import iso_deframer_pkg::*;
#(
  parameter int MAX_DBS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q0_load,
  input  logic [1:0] q0_tag,
  input  logic [7:0] q0_dbs,
  input  logic [7:0] q0_pad,
  input  logic [7:0] q0_dbc,
  input  logic [7:0] q1_top,
  input  logic [2:0] q1_rate,
  output logic       hdr_ok,
  output logic [7:0] hdr_dbs,
  output logic [7:0] hdr_dbc,
  output logic [2:0] hdr_rate
);

  logic [1:0] tag_q;
  logic [7:0] pad_q;
  logic [7:0] dbs_q;
  logic [7:0] dbc_q;
  logic       dbs_in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      pad_q <= '0;
      dbs_q <= '0;
      dbc_q <= '0;
    end else if (q0_load) begin
      tag_q <= q0_tag;
      pad_q <= q0_pad;
      dbs_q <= q0_dbs;
      dbc_q <= q0_dbc;
    end
  end

  assign dbs_in_range = (dbs_q != 8'd0) && (dbs_q <= 8'(MAX_DBS));
  assign hdr_ok       = hdr_fixed_ok(tag_q, pad_q, q1_top) && dbs_in_range;
  assign hdr_dbs      = dbs_q;
  assign hdr_dbc      = dbc_q;
  assign hdr_rate     = q1_rate;

endmodule

// File: rtl/am824_slot_decode.sv
module am824_slot_decode
  import iso_deframer_pkg::*;
#(
  parameter int CHW = 5
) (
  input  logic [CHW-1:0] slot,
  input  logic [31:0]    quad,
  output logic           pcm_hit,
  output logic [CHW-1:0] pcm_chan,
  output logic [23:0]    pcm_data,
  output logic           midi_hit,
  output logic [7:0]     midi_byte
);

  logic is_midi_slot;

  assign is_midi_slot = (slot == '0);
  assign pcm_hit      = !is_midi_slot && (quad[31:24] == LBL_PCM);
  assign pcm_chan     = slot - CHW'(1);
  assign pcm_data     = quad[23:0];
  assign midi_hit     = is_midi_slot && (quad[31:24] == LBL_MIDI1);
  assign midi_byte    = quad[23:16];

endmodule

// File: rtl/dbc_monitor.sv
module dbc_monitor
  import iso_deframer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       close_ok,
  input  logic [7:0] pkt_dbc,
  input  logic [7:0] pkt_nblk,
  output logic       dbc_err
);

  logic       have_prev_q;
  logic [7:0] expect_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      expect_q    <= '0;
      dbc_err     <= 1'b0;
    end else begin
      dbc_err <= 1'b0;
      if (close_ok) begin
        dbc_err     <= have_prev_q && (pkt_dbc != expect_q);
        expect_q    <= dbc_advance(pkt_dbc, pkt_nblk);
        have_prev_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/iso_amdtp_deframer.sv
module iso_amdtp_deframer
  import iso_deframer_pkg::*;
#(
  parameter  int MAX_DBS = 32,
  localparam int CHW     = $clog2(MAX_DBS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic [31:0]    in_data,
  output logic           pcm_valid,
  output logic [CHW-1:0] pcm_chan,
  output logic [23:0]    pcm_data,
  output logic           midi_valid,
  output logic [2:0]     midi_port,
  output logic [7:0]     midi_byte,
  output logic [2:0]     rate_code,
  output logic           hdr_err,
  output logic           len_err,
  output logic           dbc_err
);

  dfr_state_e     state;
  logic [CHW-1:0] slot_q;
  logic [7:0]     blk_q;
  logic [7:0]     dbs_q;
  logic [7:0]     dbc_q;

  // named internal events
  logic           start;
  logic           hdr_accept;
  logic           hdr_reject;
  logic           body_beat;
  logic           slot_last;
  logic           close_ok;
  logic           close_short;

  logic           hdr_ok;
  logic [7:0]     hdr_dbs;
  logic [7:0]     hdr_dbc;
  logic [2:0]     hdr_rate;

  logic           dec_pcm_hit;
  logic [CHW-1:0] dec_pcm_chan;
  logic [23:0]    dec_pcm_data;
  logic           dec_midi_hit;
  logic [7:0]     dec_midi_byte;

  iso_hdr_unit #(.MAX_DBS(MAX_DBS)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .q0_load  (start && !in_eop),
    .q0_tag   (in_data[31:30]),
    .q0_dbs   (in_data[23:16]),
    .q0_pad   (in_data[15:8]),
    .q0_dbc   (in_data[7:0]),
    .q1_top   (in_data[31:24]),
    .q1_rate  (in_data[18:16]),
    .hdr_ok   (hdr_ok),
    .hdr_dbs  (hdr_dbs),
    .hdr_dbc  (hdr_dbc),
    .hdr_rate (hdr_rate)
  );

  am824_slot_decode #(.CHW(CHW)) u_dec (
    .slot      (slot_q),
    .quad      (in_data),
    .pcm_hit   (dec_pcm_hit),
    .pcm_chan  (dec_pcm_chan),
    .pcm_data  (dec_pcm_data),
    .midi_hit  (dec_midi_hit),
    .midi_byte (dec_midi_byte)
  );

  dbc_monitor u_dbc (
    .clk      (clk),
    .rst_n    (rst_n),
    .close_ok (close_ok),
    .pkt_dbc  (dbc_q),
    .pkt_nblk (blk_q + 8'd1),
    .dbc_err  (dbc_err)
  );

  assign start       = in_valid && in_sop;
  assign hdr_accept  = in_valid && !in_sop && (state == ST_HDR1) && hdr_ok;
  assign hdr_reject  = in_valid && !in_sop && (state == ST_HDR1) && !hdr_ok;
  assign body_beat   = in_valid && !in_sop && (state == ST_BODY);
  assign slot_last   = (8'(slot_q) == (dbs_q - 8'd1));
  assign close_ok    = body_beat && in_eop && slot_last;
  assign close_short = (start && in_eop) || (body_beat && in_eop && !slot_last);

  // packet walk
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      slot_q    <= '0;
      blk_q     <= '0;
      dbs_q     <= 8'd1;
      dbc_q     <= '0;
      rate_code <= '0;
    end else if (start) begin
      state <= in_eop ? ST_IDLE : ST_HDR1;
    end else if (in_valid) begin
      unique case (state)
        ST_HDR1: begin
          if (hdr_ok) begin
            dbs_q     <= hdr_dbs;
            dbc_q     <= hdr_dbc;
            rate_code <= hdr_rate;
            slot_q    <= '0;
            blk_q     <= '0;
            state     <= in_eop ? ST_IDLE : ST_BODY;
          end else begin
            state <= in_eop ? ST_IDLE : ST_DROP;
          end
        end
        ST_BODY: begin
          if (slot_last) begin
            slot_q <= '0;
            blk_q  <= blk_q + 8'd1;
          end else begin
            slot_q <= slot_q + CHW'(1);
          end
          if (in_eop) state <= ST_IDLE;
        end
        ST_DROP: begin
          if (in_eop) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcm_valid  <= 1'b0;
      pcm_chan   <= '0;
      pcm_data   <= '0;
      midi_valid <= 1'b0;
      midi_port  <= '0;
      midi_byte  <= '0;
      hdr_err    <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      pcm_valid  <= body_beat && dec_pcm_hit;
      midi_valid <= body_beat && dec_midi_hit;
      hdr_err    <= hdr_reject;
      len_err    <= close_short;
      if (body_beat && dec_pcm_hit) begin
        pcm_chan <= dec_pcm_chan;
        pcm_data <= dec_pcm_data;
      end
      if (body_beat && dec_midi_hit) begin
        midi_byte <= dec_midi_byte;
        midi_port <= midi_port_of(dbc_q[2:0], blk_q[2:0]);
      end
    end
  end

endmodule

// File: rtl/iso_deframer_chk.sv
module iso_deframer_chk
  import iso_deframer_pkg::*;
#(
  parameter  int MAX_DBS = 32,
  localparam int CHW     = $clog2(MAX_DBS)
) (
  input logic           clk,
  input logic           rst_n,
  input dfr_state_e     state,
  input logic [CHW-1:0] slot_q,
  input logic [7:0]     dbs_q,
  input logic           hdr_accept,
  input logic           close_ok,
  input logic           pcm_valid,
  input logic [CHW-1:0] pcm_chan,
  input logic           midi_valid,
  input logic [2:0]     rate_code,
  input logic           hdr_err,
  input logic           len_err,
  input logic           dbc_err
);

  a_r1_reject_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> (!pcm_valid && !midi_valid));

  a_r2_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hdr_accept) |-> $stable(rate_code));

  a_r3_chan_inside_block: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> (8'(pcm_chan) < (dbs_q - 8'd1)));

  a_r5_midi_from_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    midi_valid |-> ($past(slot_q) == '0));

  a_r6_one_error_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_err, len_err, dbc_err}));

  a_r7_dbc_err_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    dbc_err |-> $past(close_ok));

  a_r9_output_needs_body: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid || midi_valid) |-> ($past(state) == ST_BODY));

endmodule

bind iso_amdtp_deframer iso_deframer_chk #(.MAX_DBS(MAX_DBS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state),
  .slot_q     (slot_q),
  .dbs_q      (dbs_q),
  .hdr_accept (hdr_accept),
  .close_ok   (close_ok),
  .pcm_valid  (pcm_valid),
  .pcm_chan   (pcm_chan),
  .midi_valid (midi_valid),
  .rate_code  (rate_code),
  .hdr_err    (hdr_err),
  .len_err    (len_err),
  .dbc_err    (dbc_err)
);

// File: tb/test_iso_amdtp_deframer.sv
module test_iso_amdtp_deframer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [31:0] in_data;
  logic        pcm_valid, midi_valid, hdr_err, len_err, dbc_err;
  logic [4:0]  pcm_chan;
  logic [23:0] pcm_data;
  logic [2:0]  midi_port, rate_code;
  logic [7:0]  midi_byte;

  int   errors = 0;
  int   checks = 0;
  bit   have_prev = 0;
  int   exp_next = 0;
  int   exp_rate = 0;

  always #10 clk = ~clk;

  iso_amdtp_deframer i_iso_amdtp_deframer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .pcm_valid(pcm_valid),
    .pcm_chan(pcm_chan), .pcm_data(pcm_data), .midi_valid(midi_valid),
    .midi_port(midi_port), .midi_byte(midi_byte), .rate_code(rate_code),
    .hdr_err(hdr_err), .len_err(len_err), .dbc_err(dbc_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit pv, input int pch,
                            input int pdat, input bit mv, input int mport,
                            input int mbyte, input bit he, input bit le,
                            input bit de);
    chk(req, "pcm_valid", 32'(pcm_valid), 32'(pv));
    if (pv) begin
      chk(req, "pcm_chan", 32'(pcm_chan), 32'(pch));
      chk(req, "pcm_data", 32'(pcm_data), 32'(pdat));
    end
    chk(req, "midi_valid", 32'(midi_valid), 32'(mv));
    if (mv) begin
      chk(req, "midi_port", 32'(midi_port), 32'(mport));
      chk(req, "midi_byte", 32'(midi_byte), 32'(mbyte));
    end
    chk(req, "hdr_err", 32'(hdr_err), 32'(he));
    chk(req, "len_err", 32'(len_err), 32'(le));
    chk(req, "dbc_err", 32'(dbc_err), 32'(de));
  endtask

  task automatic expect_idle(input string req);
    expect_out(req, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // one quadlet; returns just after the edge that captured it
  task automatic drive(input logic [31:0] q, input bit sop, input bit eop,
                       input bit gap);
    if (gap) begin
      in_valid = 1'b0;
      @(posedge clk); #1;
      expect_idle("R9 gap");
    end
    in_valid = 1'b1; in_data = q; in_sop = sop; in_eop = eop;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  function automatic logic [31:0] body_q(input int dbc, input int b, input int s);
    logic [23:0] smp;
    smp = {8'(dbc), 8'(b) ^ 8'h5A, 8'(s)};
    if (s == 0) begin
      if ((b + dbc) % 3 == 0)      return {8'h81, 8'(dbc * 7 + b * 13), 16'h0};
      else if ((b + dbc) % 3 == 1) return 32'h8000_0000;
      else                         return 32'h82AB_0000;
    end
    if ((s + b) % 5 == 4) return {8'h00, smp};
    return {8'h40, smp};
  endfunction

  // bad: 0 good, 1 q0 top bits, 2 q0 pad, 3 q1 top bits, 4 format, 5 dbs 0, 6 dbs too big
  task automatic send_pkt(input int dbs, input int dbc, input int nblk,
                          input int extra, input int bad, input int rate,
                          input bit gaps);
    logic [31:0] q0, q1, q;
    int  body;
    bit  ok, eop, pv, mv, de;
    q0 = {2'b00, 6'h05, 8'(dbs), 8'h00, 8'(dbc)};
    q1 = {2'b10, 6'b010000, 5'b0, 3'(rate), 16'h1234};
    case (bad)
      1: q0[31:30] = 2'b01;
      2: q0[15:8]  = 8'h01;
      3: q1[31:30] = 2'b11;
      4: q1[29:24] = 6'b000001;
      5: q0[23:16] = 8'd0;
      6: q0[23:16] = 8'd33;
      default: ;
    endcase
    ok   = (bad == 0);
    body = nblk * dbs + extra;
    drive(q0, 1, 0, gaps);
    expect_idle("R1 hdr0");
    drive(q1, 0, body == 0, gaps);
    expect_out("R1 hdr1", 0, 0, 0, 0, 0, 0, !ok, 0, 0);
    if (ok) exp_rate = rate;
    chk("R2", "rate_code", 32'(rate_code), 32'(exp_rate));
    for (int i = 0; i < body; i++) begin
      int b, s;
      b   = i / dbs;
      s   = i % dbs;
      eop = (i == body - 1);
      q   = body_q(dbc, b, s);
      drive(q, 0, eop, gaps && (i % 4 == 1));
      if (!ok) begin
        expect_idle("R1 dropped body");
      end else begin
        pv = (s > 0) && (q[31:24] == 8'h40);
        mv = (s == 0) && (q[31:24] == 8'h81);
        de = 0;
        if (eop && extra == 0) begin
          de = have_prev && (dbc != exp_next);
          exp_next  = (dbc + nblk) % 256;
          have_prev = 1;
        end
        expect_out(pv ? "R3" : (s == 0 ? "R5" : "R4"), pv, s - 1, int'(q[23:0]),
                   mv, (dbc + b) % 8, int'(q[23:16]), 0,
                   eop && extra != 0, de);
        if (eop && extra == 0 && de) chk("R7", "dbc_err seen", 32'(dbc_err), 1);
      end
    end
    chk("R2", "rate_code after", 32'(rate_code), 32'(exp_rate));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    automatic int dbs_set[5] = '{1, 2, 3, 5, 19};
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    #1;
    expect_idle("R10 reset");
    chk("R10", "rate_code reset", 32'(rate_code), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R10: first packet carries any count without a discontinuity
    send_pkt(19, 77, 2, 0, 0, 2, 0);

    // main sweep, contiguous counts, all rate codes including reserved
    for (int d = 0; d < 5; d++)
      for (int nb = 0; nb <= 8; nb++)
        send_pkt(dbs_set[d], exp_next, nb, 0, 0, (nb + d) % 8, nb % 3 == 1);

    // jump to near the wrap point, then run contiguous across it (R7)
    send_pkt(19, 250, 3, 0, 0, 1, 0);
    for (int k = 0; k < 4; k++) send_pkt(5, exp_next, 2, 0, 0, 1, 0);

    // discontinuity, then resynchronised follow-up (R7)
    send_pkt(3, (exp_next + 1) % 256, 2, 0, 0, 2, 0);
    send_pkt(3, exp_next, 1, 0, 0, 2, 0);

    // R8: empty packet with odd count changes nothing
    send_pkt(19, (exp_next + 40) % 256, 0, 0, 0, 3, 0);
    send_pkt(19, exp_next, 1, 0, 0, 3, 0);

    // R1: each kind of bad header, followed by a contiguous packet
    for (int bad = 1; bad <= 6; bad++) begin
      send_pkt(5, (exp_next + 9) % 256, 1, 0, bad, 5, bad % 2 == 0);
      send_pkt(5, exp_next, 1, 0, 0, 4, 0);
    end
    send_pkt(5, 3, 0, 0, 4, 6, 0);

    // R6: partial final block, then expectation unchanged
    send_pkt(5, (exp_next + 17) % 256, 1, 3, 0, 1, 0);
    send_pkt(5, exp_next, 2, 0, 0, 1, 0);
    send_pkt(2, exp_next, 0, 1, 0, 1, 0);

    // R6: one-quadlet packet
    drive({2'b00, 6'h0, 8'd5, 8'h0, 8'd9}, 1, 1, 0);
    expect_out("R6 short", 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R9: stray quadlets outside a packet
    drive(32'h4012_3456, 0, 0, 0);
    expect_idle("R9 stray pcm");
    drive(32'h81AA_0000, 0, 1, 0);
    expect_idle("R9 stray midi");

    // R9: abandoned packet restarted by a new start marker
    drive({2'b00, 6'h0, 8'd5, 8'h0, 8'd200}, 1, 0, 0);
    expect_idle("R9 abandoned hdr0");
    send_pkt(5, exp_next, 2, 0, 0, 0, 1);
    drive({2'b00, 6'h0, 8'd3, 8'h0, 8'd1}, 1, 0, 0);
    drive({2'b10, 6'b010000, 5'b0, 3'd7, 16'h0}, 0, 0, 0);
    drive(32'h8155_0000, 0, 0, 0);
    expect_out("R9 partial before restart", 0, 0, 0, 1, 1, 8'h55, 0, 0, 0);
    send_pkt(3, exp_next, 1, 0, 0, 6, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule